// File: doc/BRIEF.md
# Block-Linear Surface Offset Generator

This block turns a two-dimensional location on a surface, a byte column and a row, into the byte offset of that location in a block-linear memory layout. The basic tile is 64 bytes wide and 8 lines tall, 512 bytes in all. Inside a tile, bytes are arranged in 16-byte by 2-line sectors. The sectors are visited in a Z-shaped (Morton) order, and the bytes within a sector run row-major. Tiles are stacked vertically into blocks of 2^v tiles, where v is a run-time log2 height from 0 to 5. Blocks are then laid out left to right across the surface, one row of blocks after another.

A requester presents the column, the row, the surface width counted in blocks and the height exponent v. The request is accepted with a valid/ready handshake. One clock later the block returns the offset, marked valid. A height exponent above 5 is rejected: the result is flagged as an error and the offset is forced to zero.

Top module: `gob_addr_gen`

## Requirements
- R1: While reset is high, `out_valid` and `in_ready` are low. `in_ready` is high from the first clock edge after reset is released.
- R2: Each request accepted (`in_valid` and `in_ready` high at a rising edge) produces exactly one cycle with `out_valid` high, on the next edge. With no accepted request, `out_valid` stays low.
- R3: Within a sector, bytes run row-major. Offset bits [3:0] equal x[3:0], and offset bit 4 equals y[0].
- R4: Within a tile, sectors follow the Morton order, so one step right comes before one step down. Offset bits [8:5] equal {y[2], x[5], y[1], x[4]}.
- R5: A tile's position inside its block is (y >> 3) mod 2^v. It is placed at that count times 512 bytes, which fills offset bits [8+v:9] for v > 0.
- R6: The block index is (y >> (3+v)) * width + (x >> 6). The offset is the block index times 512 * 2^v, plus the tile-in-block term, plus the in-tile term.
- R7: A height exponent of 6 or 7 sets `out_err` and forces `out_offset` to 0.
- R8: Every height exponent from 0 to 5 is accepted with `out_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| in_x | input | XW | Byte column |
| in_y | input | YW | Row |
| in_wblk | input | WW | Surface width in blocks |
| in_log2h | input | 3 | log2 of tiles per block |
| out_valid | output | 1 | Result valid |
| out_err | output | 1 | Height exponent out of range |
| out_offset | output | OW | Byte offset |

## Verification
The hardest case to reach is a large height exponent combined with a row deep enough to move the tile-in-block count, the block row and the Morton bits all at once. Uniformly random rows rarely sit at the edges of a block. To reach that case, the stimulus sweeps every exponent from 0 to 7 with many random coordinates. It also adds directed corners: the last byte of a tile, the last tile of a 32-tile block, and the first row of the following block. The column is kept inside the stated surface width so that the block-row stride is exercised meaningfully.

// File: rtl/gob_addr_pkg.sv
package gob_addr_pkg;
  localparam int unsigned GOB_BYTES_LOG2 = 9;
  localparam int unsigned GOB_W_LOG2     = 6;
  localparam int unsigned GOB_H_LOG2     = 3;
  localparam int unsigned MAX_LOG2H      = 5;

  // Interleave a 2-bit sector column and a 2-bit sector row; column bits take the lower slot
  function automatic logic [3:0] morton2(input logic [1:0] col, input logic [1:0] row);
    return {row[1], col[1], row[0], col[0]};
  endfunction

  // Byte offset inside one 512-byte tile
  function automatic logic [8:0] in_tile(input logic [5:0] x, input logic [2:0] y);
    return {morton2(x[5:4], y[2:1]), y[0], x[3:0]};
  endfunction
endpackage

// File: rtl/gob_swizzle.sv
module gob_swizzle
  import gob_addr_pkg::*;
(
  input  logic [5:0] lx,
  input  logic [2:0] ly,
  output logic [8:0] tile_off
);
  always_comb tile_off = in_tile(lx, ly);
endmodule

// File: rtl/block_place.sv
module block_place #(
  parameter int unsigned XW = 16,
  parameter int unsigned YW = 16,
  parameter int unsigned WW = 10,
  parameter int unsigned OW = 40
) (
  input  logic [XW-1:0] px,
  input  logic [YW-1:0] py,
  input  logic [WW-1:0] wblk,
  input  logic [2:0]    log2h,
  output logic [OW-1:0] base_off
);
  import gob_addr_pkg::*;
  logic [YW-1:0] gob_row, gmask, gob_in_blk, blk_row;
  logic [XW-1:0] blk_col;
  logic [OW-1:0] blk_idx;

  always_comb begin
    gob_row    = py >> GOB_H_LOG2;
    gmask      = (YW'(1) << log2h) - YW'(1);
    gob_in_blk = gob_row & gmask;
    blk_row    = gob_row >> log2h;
    blk_col    = px >> GOB_W_LOG2;
    blk_idx    = OW'(blk_row) * OW'(wblk) + OW'(blk_col);
    base_off   = (blk_idx << (GOB_BYTES_LOG2 + 32'(log2h)))
               + (OW'(gob_in_blk) << GOB_BYTES_LOG2);
  end
endmodule

// File: rtl/gob_addr_gen.sv
module gob_addr_gen #(
  parameter int unsigned XW = 16,
  parameter int unsigned YW = 16,
  parameter int unsigned WW = 10,
  parameter int unsigned OW = 40
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [XW-1:0] in_x,
  input  logic [YW-1:0] in_y,
  input  logic [WW-1:0] in_wblk,
  input  logic [2:0]    in_log2h,
  output logic          out_valid,
  output logic          out_err,
  output logic [OW-1:0] out_offset
);
  import gob_addr_pkg::*;
  logic [8:0]    tile_off;
  logic [OW-1:0] base_off;
  logic          fire, bad_h;

  assign fire  = in_valid & in_ready;
  assign bad_h = in_log2h > 3'(MAX_LOG2H);

  gob_swizzle u_swz (.lx(in_x[5:0]), .ly(in_y[2:0]), .tile_off(tile_off));

  block_place #(.XW(XW), .YW(YW), .WW(WW), .OW(OW)) u_place (
    .px(in_x), .py(in_y), .wblk(in_wblk), .log2h(in_log2h), .base_off(base_off)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      in_ready   <= 1'b0;
      out_valid  <= 1'b0;
      out_err    <= 1'b0;
      out_offset <= '0;
    end else begin
      in_ready  <= 1'b1;
      out_valid <= fire;
      if (fire) begin
        out_err    <= bad_h;
        out_offset <= bad_h ? '0 : (base_off | OW'(tile_off));
      end
    end
  end
endmodule

// File: rtl/gob_addr_chk.sv
module gob_addr_chk #(
  parameter int unsigned YW = 16,
  parameter int unsigned OW = 40
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic [5:0]    cx,
  input logic [YW-1:0] in_y,
  input logic [2:0]    in_log2h,
  input logic          out_valid,
  input logic          out_err,
  input logic [OW-1:0] out_offset
);
  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid && in_ready));
  assert_issue_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);
  assert_sector_bytes_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_err) |-> out_offset[4:0] == {$past(in_y[0]), $past(cx[3:0])});
  assert_morton_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_err) |->
      out_offset[8:5] == {$past(in_y[2]), $past(cx[5]), $past(in_y[1]), $past(cx[4])});
  assert_stack_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_err) |->
      (YW'(out_offset >> 9) & ((YW'(1) << $past(in_log2h)) - YW'(1)))
        == (($past(in_y) >> 3) & ((YW'(1) << $past(in_log2h)) - YW'(1))));
  assert_reject_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_err) |-> (out_offset == '0 && $past(in_log2h) > 3'd5));
  assert_accept_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(in_log2h) <= 3'd5) |-> !out_err);
endmodule

bind gob_addr_gen gob_addr_chk #(.YW(YW), .OW(OW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .cx(in_x[5:0]), .in_y(in_y), .in_log2h(in_log2h),
  .out_valid(out_valid), .out_err(out_err), .out_offset(out_offset)
);

// File: tb/gob_addr_gen_tb.sv
module gob_addr_gen_tb;
  localparam int XW = 16, YW = 16, WW = 10, OW = 40;
  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0, in_ready;
  logic [XW-1:0] in_x = '0;
  logic [YW-1:0] in_y = '0;
  logic [WW-1:0] in_wblk = '0;
  logic [2:0] in_log2h = '0;
  logic out_valid, out_err;
  logic [OW-1:0] out_offset;
  int n_cmp = 0, n_bad = 0;

  always #2 clk = ~clk;

  gob_addr_gen #(.XW(XW), .YW(YW), .WW(WW), .OW(OW)) u_dut (.*);

  function automatic longint model(longint x, longint y, longint w, int v);
    longint scol, srow, sec, inner, gib, brow, bcol;
    if (v > 5) return 0;
    scol  = (x >> 4) & 3;
    srow  = (y >> 1) & 3;
    sec   = (scol & 1) + ((srow & 1) * 2) + (((scol >> 1) & 1) * 4) + (((srow >> 1) & 1) * 8);
    inner = sec * 32 + (y & 1) * 16 + (x & 15);
    gib   = (y >> 3) % (64'sd1 << v);
    brow  = y >> (3 + v);
    bcol  = x >> 6;
    return (brow * w + bcol) * (64'sd512 << v) + gib * 512 + inner;
  endfunction

  task automatic check(string req, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic req(int x, int y, int w, int v, string tag);
    @(negedge clk);
    in_x = XW'(x); in_y = YW'(y); in_wblk = WW'(w); in_log2h = 3'(v); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 valid", longint'(out_valid), 1);
    check((v > 5) ? "R7 err" : "R8 err", longint'(out_err), (v > 5) ? 1 : 0);
    check(tag, longint'(out_offset), model(x, y, w, v));
    @(negedge clk);
    check("R2 idle", longint'(out_valid), 0);
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 valid in reset", longint'(out_valid), 0);
    check("R1 ready in reset", longint'(in_ready), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 ready after reset", longint'(in_ready), 1);
    check("R2 no request", longint'(out_valid), 0);
    // directed corners
    req(0, 0, 1, 0, "R6 origin");
    req(63, 7, 1, 0, "R4 last tile byte");
    req(16, 0, 1, 0, "R4 one step right");
    req(0, 2, 1, 0, "R4 one step down");
    req(5, 1, 1, 0, "R3 second line");
    req(0, 255, 4, 5, "R5 last tile of tall block");
    req(0, 256, 4, 5, "R6 next block row");
    req(130, 9, 7, 1, "R5 second tile");
    req(64*9+3, 40, 10, 2, "R6 stride");
    req(12, 34, 3, 6, "R7 reject 6");
    req(12, 34, 3, 7, "R7 reject 7");
    // random sweep over every height exponent
    for (int v = 0; v < 8; v++) begin
      for (int k = 0; k < 60; k++) begin
        int w, x, y;
        w = 1 + int'($urandom % 1023);
        x = int'($urandom % (w * 64));
        y = int'($urandom % 65536);
        req(x, y, w, v, (v > 5) ? "R7 random" : "R6 random");
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule